// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Copy Engine

This block copies a run of words from one address to another on a shared system bus, without any help from the processor after setup. Software loads a source pointer, a destination pointer and a word count through a small register window, then writes a control word whose lowest bit launches the job. To use the bus, the engine raises a request line to the current bus owner. It issues no read or write strobe until the owner answers on a grant line. Each unit is a single-word read from the source pointer followed by a write of that same word to the destination pointer. Both accesses stretch for as long as the slave holds its ready line low.

A two-bit field in the control word sets how long the engine holds the bus. In block mode it keeps the bus from the first grant to the last word. In steal mode it gives the bus back after every word and then asks again. In idle-slot mode it asks only when the processor signals that it is not using the bus, and it also gives the bus back after every word. When the count runs out, a done flag is set. The interrupt line is that flag gated by an enable bit. A direction bit together with a hold-address bit can keep the device-side pointer fixed, which suits a data port at a single address.

Top module: `dma_single`

## Requirements
- R1: Register window at byte offsets 0x00 source pointer, 0x04 destination pointer, 0x08 count, 0x0C control, 0x10 status. All registers read zero after reset. Pointers and count read back what was written, and control bit 0 always reads 0.
- R2: Control word fields: bit0 start, bit1 device-to-memory, bit2 memory-to-device, bit3 interrupt enable, bits5:4 mode (00 block, 01 steal, 10 idle-slot, 11 block), bit6 hold device-side address. Each unit reads the source pointer and then writes the word it read to the destination pointer. Read and write strobes are never high together, and neither is high unless both request and grant are high.
- R3: After each unit the count drops by one and both pointers advance by the word size (4 bytes). If bit6 is set, the source stays fixed when bit1 is set, otherwise the destination stays fixed when bit2 is set. The count reads 0 after completion.
- R4: A strobe and its address stay unchanged until the slave's ready input is seen high.
- R5: In block mode the request stays high from the first request until the last word is written.
- R6: In steal mode exactly one unit is moved per grant, and the request drops for at least one cycle after each unit.
- R7: In idle-slot mode the request rises only in the cycle after the processor-idle input was sampled high, and the request drops after each unit.
- R8: Status bit0 is busy and status bit1 is done. On completion busy clears and done sets. The interrupt output equals done AND control bit3.
- R9: Writing status with bit1 = 1 clears done. Writing bit1 = 0 leaves done unchanged.
- R10: While busy, writes to the pointer, count and control registers are ignored, including a new start.
- R11: A start with count 0 sets done without ever raising the request.
- R12: An accepted start clears done, and busy reads 1 in the cycle after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| hold | output | 1 | Bus request to the bus owner |
| hlda | input | 1 | Bus grant from the bus owner |
| cpuIdle | input | 1 | Processor is not using the bus |
| busAddr | output | 32 | Master address |
| busRd | output | 1 | Master read strobe |
| busWr | output | 1 | Master write strobe |
| busWdata | output | 32 | Master write data |
| busRdata | input | 32 | Master read data |
| busReady | input | 1 | Slave completes the current access |
| irq | output | 1 | Completion interrupt |

## Verification
Each mode is exercised against a bus owner whose grant delay can be set and a slave that inserts a chosen number of wait states. Block mode with no wait states checks that the request stays high across the whole job. Steal mode with wait states and a fixed source checks that only one unit moves per grant and that strobes stretch correctly. Idle-slot mode with a sparse idle pattern and a fixed destination separates requests that follow an idle sample from requests that do not. Mid-job register writes, a zero-count start and status clear writes check the control-path corner cases. Every access is compared against a queue of expected addresses and data.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    MODE_BURST = 2'b00,
    MODE_STEAL = 2'b01,
    MODE_TRANS = 2'b10,
    MODE_RSVD  = 2'b11
  } busMode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_WAIT,
    S_REQ,
    S_READ,
    S_WRITE,
    S_GAP
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // start taken
    logic latch;    // capture read data
    logic advance;  // unit finished: step pointers and count
    logic setDone;  // job complete
  } engStrobes_t;

  localparam logic [4:0] OFS_SRC  = 5'h00;
  localparam logic [4:0] OFS_DST  = 5'h04;
  localparam logic [4:0] OFS_CNT  = 5'h08;
  localparam logic [4:0] OFS_CTRL = 5'h0C;
  localparam logic [4:0] OFS_STAT = 5'h10;

  localparam int CB_START = 0;
  localparam int CB_TOMEM = 1;
  localparam int CB_TODEV = 2;
  localparam int CB_IRQEN = 3;
  localparam int CB_MODE  = 4;
  localparam int CB_FIX   = 6;

  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busy,
  input  engStrobes_t       stb,
  input  logic              selDst,
  input  logic [DATA_W-1:0] busRdata,
  output logic              startReq,
  output logic              cntZero,
  output logic              cntOne,
  output busMode_t          curMode,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              irq
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [CNT_W-1:0]  cntReg;
  logic              toMem, toDev, irqEn, fixDev, doneFlag;
  logic [DATA_W-1:0] dataHold;
  logic              cfgWr, fixSrc, fixDst, doneClr;

  assign cfgWr    = regWrEn && !busy;
  assign startReq = regWrEn && (regAddr == OFS_CTRL) && regWdata[CB_START];
  assign doneClr  = regWrEn && (regAddr == OFS_STAT) && regWdata[SB_DONE];
  assign fixSrc   = fixDev && toMem;
  assign fixDst   = fixDev && toDev && !toMem;
  assign cntZero  = (cntReg == '0);
  assign cntOne   = (cntReg == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      cntReg  <= '0;
      toMem   <= 1'b0;
      toDev   <= 1'b0;
      irqEn   <= 1'b0;
      fixDev  <= 1'b0;
      curMode <= MODE_BURST;
    end else if (cfgWr) begin
      case (regAddr)
        OFS_SRC:  srcAddr <= regWdata[ADDR_W-1:0];
        OFS_DST:  dstAddr <= regWdata[ADDR_W-1:0];
        OFS_CNT:  cntReg  <= regWdata[CNT_W-1:0];
        OFS_CTRL: begin
          toMem   <= regWdata[CB_TOMEM];
          toDev   <= regWdata[CB_TODEV];
          irqEn   <= regWdata[CB_IRQEN];
          fixDev  <= regWdata[CB_FIX];
          curMode <= busMode_t'(regWdata[CB_MODE+1:CB_MODE]);
        end
        default: ;
      endcase
    end else if (stb.advance) begin
      if (!fixSrc) srcAddr <= srcAddr + ADDR_STEP;
      if (!fixDst) dstAddr <= dstAddr + ADDR_STEP;
      cntReg <= cntReg - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataHold <= '0;
    end else if (stb.latch) begin
      dataHold <= busRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             doneFlag <= 1'b0;
    else if (stb.setDone)  doneFlag <= 1'b1;
    else if (stb.accept)   doneFlag <= 1'b0;
    else if (doneClr)      doneFlag <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_SRC:  regRdata = 32'(srcAddr);
      OFS_DST:  regRdata = 32'(dstAddr);
      OFS_CNT:  regRdata = 32'(cntReg);
      OFS_CTRL: begin
        regRdata[CB_TOMEM]           = toMem;
        regRdata[CB_TODEV]           = toDev;
        regRdata[CB_IRQEN]           = irqEn;
        regRdata[CB_MODE+1:CB_MODE]  = curMode;
        regRdata[CB_FIX]             = fixDev;
      end
      OFS_STAT: begin
        regRdata[SB_BUSY] = busy;
        regRdata[SB_DONE] = doneFlag;
      end
      default: regRdata = '0;
    endcase
  end

  assign busAddr  = selDst ? dstAddr : srcAddr;
  assign busWdata = dataHold;
  assign irq      = doneFlag && irqEn;

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cntZero,
  input  logic        cntOne,
  input  busMode_t    curMode,
  input  logic        hlda,
  input  logic        cpuIdle,
  input  logic        busReady,
  output engStrobes_t stb,
  output logic        hold,
  output logic        busRd,
  output logic        busWr,
  output logic        busy
);

  engState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          stb.accept = 1'b1;
          nextState  = S_ARM;
        end
      end
      S_ARM: begin
        if (cntZero) begin
          stb.setDone = 1'b1;
          nextState   = S_IDLE;
        end else if (curMode == MODE_TRANS) begin
          nextState = S_WAIT;
        end else begin
          nextState = S_REQ;
        end
      end
      S_WAIT:  if (cpuIdle) nextState = S_REQ;
      S_REQ:   if (hlda)    nextState = S_READ;
      S_READ: begin
        if (busReady) begin
          stb.latch = 1'b1;
          nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        if (busReady) begin
          stb.advance = 1'b1;
          if (cntOne) begin
            stb.setDone = 1'b1;
            nextState   = S_IDLE;
          end else begin
            case (curMode)
              MODE_STEAL: nextState = S_GAP;
              MODE_TRANS: nextState = S_WAIT;
              default:    nextState = S_READ;
            endcase
          end
        end
      end
      S_GAP:   nextState = S_REQ;
      default: nextState = S_IDLE;
    endcase
  end

  assign hold  = (state == S_REQ) || (state == S_READ) || (state == S_WRITE);
  assign busRd = (state == S_READ);
  assign busWr = (state == S_WRITE);
  assign busy  = (state != S_IDLE);

endmodule

// File: rtl/dma_single.sv
module dma_single
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              hold,
  input  logic              hlda,
  input  logic              cpuIdle,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              irq
);

  engStrobes_t stb;
  logic        startReq, cntZero, lastUnit, busy;
  busMode_t    curMode;

  dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busy),
    .stb      (stb),
    .selDst   (busWr),
    .busRdata (busRdata),
    .startReq (startReq),
    .cntZero  (cntZero),
    .cntOne   (lastUnit),
    .curMode  (curMode),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .irq      (irq)
  );

  dma_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cntZero  (cntZero),
    .cntOne   (lastUnit),
    .curMode  (curMode),
    .hlda     (hlda),
    .cpuIdle  (cpuIdle),
    .busReady (busReady),
    .stb      (stb),
    .hold     (hold),
    .busRd    (busRd),
    .busWr    (busWr),
    .busy     (busy)
  );

endmodule

// File: rtl/dma_single_chk.sv
module dma_single_chk
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hold,
  input logic              hlda,
  input logic              cpuIdle,
  input logic              busRd,
  input logic              busWr,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              irq,
  input logic              busy,
  input logic              lastUnit,
  input busMode_t          curMode
);

  // R2
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (hold && hlda));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R4
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busReady) |=> (busRd && $stable(busAddr)));

  // R4
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busReady) |=> (busWr && $stable(busAddr)));

  // R5
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busReady && !lastUnit && (curMode == MODE_BURST || curMode == MODE_RSVD)) |=> hold);

  // R6
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busReady && curMode == MODE_STEAL) |=> !hold);

  // R7
  trans_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hold) && curMode == MODE_TRANS) |-> $past(cpuIdle));

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && !hold));

endmodule

bind dma_single dma_single_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hold     (hold),
  .hlda     (hlda),
  .cpuIdle  (cpuIdle),
  .busRd    (busRd),
  .busWr    (busWr),
  .busReady (busReady),
  .busAddr  (busAddr),
  .irq      (irq),
  .busy     (busy),
  .lastUnit (lastUnit),
  .curMode  (curMode)
);

// File: tb/dma_single_bench.sv
module dma_single_bench;
  import dma_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        hold;
  logic        hlda = 1'b0;
  logic        cpuIdle = 1'b1;
  logic [31:0] busAddr;
  logic        busRd, busWr;
  logic [31:0] busWdata, busRdata;
  logic        busReady = 1'b0;
  logic        irq;

  dma_single u_dma_single (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .hold(hold), .hlda(hlda),
    .cpuIdle(cpuIdle), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] memVal(logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  assign busRdata = busRd ? memVal(busAddr) : 32'h0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model state
  logic [31:0] expRdQ[$];
  logic [31:0] expWrAQ[$];
  logic [31:0] expWrDQ[$];
  busMode_t    benchMode = MODE_BURST;
  int          grantDelay = 0;
  int          waitStates = 0;
  bit          idlePattern = 1'b0;
  int          cyc = 0, grantCnt = 0, readyCnt = 0, wrInWindow = 0;
  bit          prevHold = 1'b0, prevIdle = 1'b1, sawHold = 1'b0;

  // Bus owner, slave and per-clock comparison
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!hold) begin
        hlda = 1'b0;
        grantCnt = 0;
      end else if (!hlda) begin
        if (grantCnt >= grantDelay) hlda = 1'b1;
        else grantCnt++;
      end
      if (busRd || busWr) begin
        if (readyCnt >= waitStates) begin busReady = 1'b1; readyCnt = 0; end
        else begin busReady = 1'b0; readyCnt++; end
      end else begin
        busReady = 1'b0;
        readyCnt = 0;
      end
      cpuIdle = idlePattern ? ((cyc % 4) == 0) : 1'b1;

      if (hold) sawHold = 1'b1;
      if (!hold) wrInWindow = 0;
      if ((busRd || busWr) && !(hold && hlda))
        check(1'b0, "R2 strobe without grant", {30'b0, hold, hlda}, 32'h3);
      if (busRd && busReady) begin
        if (expRdQ.size() == 0) check(1'b0, "R2 unexpected read", busAddr, 32'h0);
        else begin
          logic [31:0] ea;
          ea = expRdQ.pop_front();
          check(busAddr == ea, "R3 read address", busAddr, ea);
        end
      end
      if (busWr && busReady) begin
        wrInWindow++;
        if (expWrAQ.size() == 0) check(1'b0, "R2 unexpected write", busAddr, 32'h0);
        else begin
          logic [31:0] ea, ed;
          ea = expWrAQ.pop_front();
          ed = expWrDQ.pop_front();
          check(busAddr == ea, "R3 write address", busAddr, ea);
          check(busWdata == ed, "R2 write data", busWdata, ed);
        end
        if (benchMode == MODE_STEAL && wrInWindow > 1)
          check(1'b0, "R6 two units in one grant", wrInWindow, 1);
        if (benchMode == MODE_TRANS && wrInWindow > 1)
          check(1'b0, "R7 two units in one grant", wrInWindow, 1);
      end
      if (!prevHold && hold && benchMode == MODE_TRANS)
        check(prevIdle, "R7 request without idle", {31'b0, prevIdle}, 32'h1);
      if (prevHold && !hold && benchMode == MODE_BURST && expWrAQ.size() != 0)
        check(1'b0, "R5 request dropped mid block", expWrAQ.size(), 0);
      prevHold = hold;
      prevIdle = cpuIdle;
    end
  end

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic setupXfer(input logic [31:0] src, input logic [31:0] dst, input int n,
                           input logic [31:0] ctl);
    bit fs, fd;
    fs = ctl[6] && ctl[1];
    fd = ctl[6] && ctl[2] && !ctl[1];
    benchMode = (ctl[5:4] == 2'b11) ? MODE_BURST : busMode_t'(ctl[5:4]);
    for (int k = 0; k < n; k++) begin
      logic [31:0] ra, wa;
      ra = fs ? src : src + 32'(4 * k);
      wa = fd ? dst : dst + 32'(4 * k);
      expRdQ.push_back(ra);
      expWrAQ.push_back(wa);
      expWrDQ.push_back(memVal(ra));
    end
    wrReg(OFS_SRC, src);
    wrReg(OFS_DST, dst);
    wrReg(OFS_CNT, 32'(n));
    wrReg(OFS_CTRL, ctl | 32'h1);
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] s;
    int guard = 0;
    do begin
      @(negedge clk); #2;
      rdReg(OFS_STAT, s);
      guard++;
    end while (s[0] && guard < 5000);
    check(s[0] == 1'b0, {tag, " busy cleared"}, s, 32'h2);
  endtask

  task automatic finishXfer(input string tag, input logic [31:0] src, input logic [31:0] dst,
                            input int n, input logic [31:0] ctl);
    logic [31:0] v, es, ed;
    bit fs, fd;
    fs = ctl[6] && ctl[1];
    fd = ctl[6] && ctl[2] && !ctl[1];
    waitIdle(tag);
    check(expWrAQ.size() == 0 && expRdQ.size() == 0, {tag, " R2 all units moved"},
          expWrAQ.size(), 0);
    rdReg(OFS_STAT, v);
    check(v == 32'h2, {tag, " R8 status done"}, v, 32'h2);
    check(irq == ctl[3], {tag, " R8 irq"}, {31'b0, irq}, {31'b0, ctl[3]});
    rdReg(OFS_CNT, v);
    check(v == 0, {tag, " R3 count zero"}, v, 0);
    es = fs ? src : src + 32'(4 * n);
    ed = fd ? dst : dst + 32'(4 * n);
    rdReg(OFS_SRC, v);
    check(v == es, {tag, " R3 final source"}, v, es);
    rdReg(OFS_DST, v);
    check(v == ed, {tag, " R3 final destination"}, v, ed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;

    // R1 reset state
    rdReg(OFS_SRC, v);  check(v == 0, "R1 reset source", v, 0);
    rdReg(OFS_DST, v);  check(v == 0, "R1 reset destination", v, 0);
    rdReg(OFS_CNT, v);  check(v == 0, "R1 reset count", v, 0);
    rdReg(OFS_CTRL, v); check(v == 0, "R1 reset control", v, 0);
    rdReg(OFS_STAT, v); check(v == 0, "R1 reset status", v, 0);
    check(!hold && !irq && !busRd && !busWr, "R1 reset outputs",
          {28'b0, hold, irq, busRd, busWr}, 0);

    // R1 readback, control without start does nothing
    wrReg(OFS_SRC, 32'h1000_0040);
    wrReg(OFS_DST, 32'h2000_0080);
    wrReg(OFS_CNT, 32'h0000_1234);
    wrReg(OFS_CTRL, 32'h0000_007E);
    #2;
    rdReg(OFS_SRC, v);  check(v == 32'h1000_0040, "R1 source readback", v, 32'h1000_0040);
    rdReg(OFS_DST, v);  check(v == 32'h2000_0080, "R1 destination readback", v, 32'h2000_0080);
    rdReg(OFS_CNT, v);  check(v == 32'h1234, "R1 count readback", v, 32'h1234);
    rdReg(OFS_CTRL, v); check(v == 32'h7E, "R1 control readback", v, 32'h7E);
    rdReg(OFS_STAT, v); check(v == 0, "R1 no start no busy", v, 0);

    // R5 block mode, irq enabled, incrementing source
    grantDelay = 2; waitStates = 0; idlePattern = 1'b0;
    setupXfer(32'h0000_1000, 32'h0000_8000, 4, 32'h0000_000A);
    finishXfer("burst", 32'h0000_1000, 32'h0000_8000, 4, 32'h0000_000A);

    // R9 write-one-to-clear
    wrReg(OFS_STAT, 32'h0); #2;
    rdReg(OFS_STAT, v); check(v == 32'h2, "R9 zero write keeps done", v, 32'h2);
    wrReg(OFS_STAT, 32'h2); #2;
    rdReg(OFS_STAT, v); check(v == 32'h0, "R9 done cleared", v, 32'h0);
    check(irq == 1'b0, "R9 irq cleared", {31'b0, irq}, 0);

    // R6 steal mode with wait states, fixed source (R4), irq disabled
    grantDelay = 1; waitStates = 2;
    setupXfer(32'h0000_3000, 32'h0000_9000, 3, 32'h0000_0052);
    finishXfer("steal", 32'h0000_3000, 32'h0000_9000, 3, 32'h0000_0052);

    // R10 writes while busy ignored
    grantDelay = 3; waitStates = 1;
    setupXfer(32'h0000_4000, 32'h0000_A000, 6, 32'h0000_0018);
    repeat (8) @(negedge clk);
    wrReg(OFS_SRC, 32'hDEAD_0000);
    wrReg(OFS_CNT, 32'h1);
    wrReg(OFS_CTRL, 32'h0000_0001);
    #2;
    rdReg(OFS_CTRL, v); check(v == 32'h18, "R10 control unchanged while busy", v, 32'h18);
    finishXfer("R10 busy", 32'h0000_4000, 32'h0000_A000, 6, 32'h0000_0018);

    // R7 idle-slot mode, fixed destination
    grantDelay = 0; waitStates = 1; idlePattern = 1'b1;
    setupXfer(32'h0000_5000, 32'h0000_B000, 3, 32'h0000_0064);
    finishXfer("trans", 32'h0000_5000, 32'h0000_B000, 3, 32'h0000_0064);
    idlePattern = 1'b0;

    // R11 zero count
    benchMode = MODE_BURST;
    wrReg(OFS_CNT, 32'h0);
    sawHold = 1'b0;
    wrReg(OFS_CTRL, 32'h0000_0009);
    repeat (4) @(negedge clk); #2;
    check(sawHold == 1'b0, "R11 no request on zero count", {31'b0, sawHold}, 0);
    rdReg(OFS_STAT, v); check(v == 32'h2, "R11 done on zero count", v, 32'h2);
    check(irq == 1'b1, "R11 irq on zero count", {31'b0, irq}, 1);

    // R12 new start clears done
    grantDelay = 1; waitStates = 0;
    setupXfer(32'h0000_6000, 32'h0000_C000, 2, 32'h0000_0000);
    #2;
    rdReg(OFS_STAT, v); check(v == 32'h1, "R12 busy and done cleared", v, 32'h1);
    finishXfer("R12 run", 32'h0000_6000, 32'h0000_C000, 2, 32'h0000_0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule